// File: doc/BRIEF.md
# Macro-instruction expansion sequencer

This block turns one assembler-level macro-instruction into the real 32-bit machine words that carry it out. It emits one word per cycle. A macro arrives on a valid/ready port. It carries a 3-bit macro code, a destination register, a source register and a 32-bit operand. The output is a valid/ready stream of encoded words, and a last flag marks the final word of each expansion.

The number of words depends on the operand value. A load-immediate or add-immediate whose operand survives sign extension from 16 bits takes a single word. A wider operand is built from an upper-half load and an OR of the lower half. Rotates and wide add-immediates use register 1 as a scratch register, and only those long sequences write it. The block captures the request, works out the length and every word combinationally from the captured request, and then steps through the words under output back-pressure.

Top module: `macro_expander`

## Requirements
- R1: While reset is low at a clock edge, the block ends that cycle with out_valid low and in_ready high, and any expansion in progress is dropped.
- R2: in_ready is high only when no expansion is pending. A macro accepted at an edge shows its first word with out_valid high in the next cycle. in_ready stays low until the edge that takes the last word, after which out_valid is low and in_ready is high.
- R3: While out_valid is high and out_ready is low, out_data and out_last hold their values at the next edge.
- R4: out_last is high on the final word of each expansion and on no other word, and no expansion is longer than three words.
- R5: Macro code 1 (move) emits one R-format add with rs=0, rt=source and rd=destination.
- R6: Macro code 2 (load immediate) emits one addi (opcode 8, rs=0, rt=destination, immediate = operand[15:0]) when the operand equals the sign extension of its low 16 bits.
- R7: For any other operand, macro code 2 emits lui (opcode 15, rs=0, rt=destination, immediate = operand[31:16]) followed by ori (opcode 13, rs=rt=destination, immediate = operand[15:0]).
- R8: Macro code 3 (rotate right of the destination register by n = operand[4:0], n nonzero) emits, in order: srl with rt=destination, rd=1 and shift n (function 2); sll with rt=rd=destination and shift 32-n (function 0); or with rs=destination, rt=1 and rd=destination (function 37).
- R9: Macro code 3 with operand[4:0] = 0 emits the single all-zero word, so no shift by 32 is ever encoded.
- R10: Macro code 0 (nop), and the unused codes 5, 6 and 7, emit the single all-zero word.
- R11: Macro code 4 (add unsigned with immediate) emits one addiu (opcode 9, rs=source, rt=destination, immediate = operand[15:0]) when the operand fits in 16 bits as in R6.
- R12: For any other operand, macro code 4 emits lui (rt=1, upper half), then ori (rs=rt=1, lower half), then addu with rs=source, rt=1, rd=destination and function 33.
- R13: Every word puts the opcode in bits 31:26, rs in 25:21 and rt in 20:16. R-format words have opcode 0, rd in 15:11, the shift in 10:6 and the function code in 5:0, and an add has function code 32. I-format words put the immediate in bits 15:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Macro request present |
| in_ready | output | 1 | Block can accept a macro |
| in_op | input | 3 | Macro code |
| in_dst | input | 5 | Destination register |
| in_src | input | 5 | Source register |
| in_imm | input | 32 | Immediate operand or rotate amount |
| out_valid | output | 1 | Encoded word present |
| out_ready | input | 1 | Consumer takes the word at this edge |
| out_data | output | 32 | Encoded machine word |
| out_last | output | 1 | Word is the final one of its expansion |

## Verification
The load-immediate and add-immediate forms are driven with operands on both sides of the 16-bit sign-extension boundary: 0x7FFF against 0x8000, 0xFFFF8000 against 0xFFFF7FFF, and all-ones and 0x10000. This separates a correct fit test from one that only checks the upper half for zero. Every rotate amount from 0 to 31 is applied, together with amounts that have high operand bits set, which exposes errors in the complemented shift and in the zero-amount case. Register pairs that differ in every field position catch swapped rs, rt and rd slots. Alternating output stalls, together with a reset in the middle of a sequence, test how the words hold and how the sequence steps.

// File: rtl/mxp_pkg.sv
// Package: shared widths, macro codes, field codes and encoding helpers
// for the macro expansion sequencer. Assumes a 32-bit word with 5-bit
// register specifiers and 6-bit opcode/function fields.
package mxp_pkg;

    localparam int WORD_W  = 32;
    localparam int REG_W   = 5;
    localparam int OPC_W   = 6;
    localparam int FN_W    = 6;
    localparam int SH_W    = 5;
    localparam int HALF_W  = WORD_W / 2;
    localparam int MAC_W   = 3;
    localparam int MAX_LEN = 3;
    localparam int LEN_W   = $clog2(MAX_LEN + 1);
    localparam int IDX_W   = $clog2(MAX_LEN);

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [REG_W-1:0]  reg_t;
    typedef logic [HALF_W-1:0] half_t;
    typedef logic [SH_W-1:0]   sh_t;

    typedef enum logic [MAC_W-1:0] {
        MAC_NOP   = 3'd0,
        MAC_MOVE  = 3'd1,
        MAC_LDI   = 3'd2,
        MAC_ROTR  = 3'd3,
        MAC_ADDUI = 3'd4
    } mac_op_t;

    localparam logic [OPC_W-1:0] OPC_SPECIAL = 6'd0;
    localparam logic [OPC_W-1:0] OPC_ADDI    = 6'd8;
    localparam logic [OPC_W-1:0] OPC_ADDIU   = 6'd9;
    localparam logic [OPC_W-1:0] OPC_ORI     = 6'd13;
    localparam logic [OPC_W-1:0] OPC_LUI     = 6'd15;

    localparam logic [FN_W-1:0] FN_SLL  = 6'd0;
    localparam logic [FN_W-1:0] FN_SRL  = 6'd2;
    localparam logic [FN_W-1:0] FN_ADD  = 6'd32;
    localparam logic [FN_W-1:0] FN_ADDU = 6'd33;
    localparam logic [FN_W-1:0] FN_OR   = 6'd37;

    localparam reg_t REG_ZERO    = 5'd0;
    localparam reg_t REG_SCRATCH = 5'd1;

    // Captured macro request.
    typedef struct packed {
        logic [MAC_W-1:0] op;
        reg_t             dst;
        reg_t             src;
        word_t            imm;
    } mac_req_t;

    // Register-to-register word layout.
    function automatic word_t enc_r(reg_t rs, reg_t rt, reg_t rd, sh_t sh,
                                    logic [FN_W-1:0] fn);
        return {OPC_SPECIAL, rs, rt, rd, sh, fn};
    endfunction

    // Immediate word layout.
    function automatic word_t enc_i(logic [OPC_W-1:0] opc, reg_t rs, reg_t rt,
                                    half_t imm);
        return {opc, rs, rt, imm};
    endfunction

    // True when the value survives sign extension from its low half.
    function automatic logic fits_half(word_t v);
        return v == {{HALF_W{v[HALF_W-1]}}, v[HALF_W-1:0]};
    endfunction

endpackage

// File: rtl/mxp_req_hold.sv
// Request holding register: captures the macro request on load and keeps
// it for the whole expansion. Assumes load is only raised when idle.
module mxp_req_hold
    import mxp_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load,
    input  mac_req_t req_in,
    output mac_req_t req_q
);

    // Capture the request at acceptance; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= '0;
        end else if (load) begin
            req_q <= req_in;
        end
    end

endmodule

// File: rtl/mxp_planner.sv
// Expansion planner: from a held request, computes the sequence length and
// every encoded word of the expansion. Purely combinational. Assumes the
// scratch register is reserved and never named by the caller.
module mxp_planner
    import mxp_pkg::*;
#(
    parameter reg_t SCRATCH = REG_SCRATCH
) (
    input  mac_req_t                        req,
    output logic [LEN_W-1:0]                len,
    output logic [MAX_LEN-1:0][WORD_W-1:0]  words
);

    half_t hi_half;
    half_t lo_half;
    sh_t   rot_amt;
    sh_t   rot_back;
    logic  short_form;

    assign hi_half    = req.imm[WORD_W-1:HALF_W];
    assign lo_half    = req.imm[HALF_W-1:0];
    assign rot_amt    = req.imm[SH_W-1:0];
    assign rot_back   = sh_t'(0) - rot_amt;
    assign short_form = fits_half(req.imm);

    // Select length and words for the held macro code.
    always_comb begin
        len   = LEN_W'(1);
        words = '0;
        case (req.op)
            MAC_MOVE: begin
                words[0] = enc_r(REG_ZERO, req.src, req.dst, '0, FN_ADD);
            end
            MAC_LDI: begin
                if (short_form) begin
                    words[0] = enc_i(OPC_ADDI, REG_ZERO, req.dst, lo_half);
                end else begin
                    len      = LEN_W'(2);
                    words[0] = enc_i(OPC_LUI, REG_ZERO, req.dst, hi_half);
                    words[1] = enc_i(OPC_ORI, req.dst, req.dst, lo_half);
                end
            end
            MAC_ROTR: begin
                if (rot_amt != '0) begin
                    len      = LEN_W'(3);
                    words[0] = enc_r(REG_ZERO, req.dst, SCRATCH, rot_amt, FN_SRL);
                    words[1] = enc_r(REG_ZERO, req.dst, req.dst, rot_back, FN_SLL);
                    words[2] = enc_r(req.dst, SCRATCH, req.dst, '0, FN_OR);
                end
            end
            MAC_ADDUI: begin
                if (short_form) begin
                    words[0] = enc_i(OPC_ADDIU, req.src, req.dst, lo_half);
                end else begin
                    len      = LEN_W'(3);
                    words[0] = enc_i(OPC_LUI, REG_ZERO, SCRATCH, hi_half);
                    words[1] = enc_i(OPC_ORI, SCRATCH, SCRATCH, lo_half);
                    words[2] = enc_r(req.src, SCRATCH, req.dst, '0, FN_ADDU);
                end
            end
            default: begin
                words[0] = '0;
            end
        endcase
    end

endmodule

// File: rtl/mxp_stepper.sv
// Sequence stepper: idle/busy control and word index. Accepts a macro only
// when idle, advances on each taken word and returns to idle after the last.
// Assumes len is between 1 and MAX_LEN while busy.
module mxp_stepper
    import mxp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             out_ready,
    input  logic [LEN_W-1:0] len,
    output logic             load,
    output logic             busy,
    output logic             last,
    output logic [IDX_W-1:0] idx
);

    assign load = in_valid && !busy;
    assign last = busy && (LEN_W'(idx) == (len - LEN_W'(1)));

    // Track busy state and the index of the word on the output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            idx  <= '0;
        end else if (load) begin
            busy <= 1'b1;
            idx  <= '0;
        end else if (busy && out_ready) begin
            if (last) begin
                busy <= 1'b0;
                idx  <= '0;
            end else begin
                idx  <= idx + IDX_W'(1);
            end
        end
    end

endmodule

// File: rtl/macro_expander.sv
// Top: macro-instruction expansion sequencer. Accepts one macro per
// handshake and streams its machine words one per cycle, with a last flag.
// Assumes consumers honour valid/ready; words are stable while stalled.
module macro_expander
    import mxp_pkg::*;
#(
    parameter reg_t SCRATCH = REG_SCRATCH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [MAC_W-1:0]  in_op,
    input  logic [REG_W-1:0]  in_dst,
    input  logic [REG_W-1:0]  in_src,
    input  logic [WORD_W-1:0] in_imm,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data,
    output logic              out_last
);

    mac_req_t                       req_in;
    mac_req_t                       req_q;
    logic                           load;
    logic                           busy;
    logic                           last;
    logic [IDX_W-1:0]               idx;
    logic [LEN_W-1:0]               len;
    logic [MAX_LEN-1:0][WORD_W-1:0] words;

    assign req_in = '{op: in_op, dst: in_dst, src: in_src, imm: in_imm};

    mxp_req_hold u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .req_in (req_in),
        .req_q  (req_q)
    );

    mxp_planner #(.SCRATCH(SCRATCH)) u_plan (
        .req   (req_q),
        .len   (len),
        .words (words)
    );

    mxp_stepper u_step (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .len       (len),
        .load      (load),
        .busy      (busy),
        .last      (last),
        .idx       (idx)
    );

    assign in_ready  = !busy;
    assign out_valid = busy;
    assign out_data  = words[idx];
    assign out_last  = last;

endmodule

// File: rtl/macro_expander_check.sv
// Checker: protocol and sequencing properties of macro_expander, observed
// at its ports. Bound to every instance of the top module.
module macro_expander_check
    import mxp_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [WORD_W-1:0] out_data,
    input logic              out_last
);

    logic [LEN_W-1:0] taken;

    // Count words taken within the current expansion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taken <= '0;
        end else if (out_valid && out_ready) begin
            taken <= out_last ? '0 : taken + LEN_W'(1);
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && in_ready));

    assert_busy_not_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    assert_accept_shows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    assert_hold_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_data) && $stable(out_last)));

    assert_last_ends_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> (!out_valid && in_ready));

    assert_max_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |-> (taken < LEN_W'(MAX_LEN - 1)));

    assert_zero_word_alone_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_data == '0) |-> out_last);

endmodule

bind macro_expander macro_expander_check u_check (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_last  (out_last)
);

// File: tb/macro_expander_test.sv
// Bench: sweeps macro codes, boundary operands, all rotate amounts and
// register pairs; expected words are built arithmetically from the brief.
module macro_expander_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [2:0]  in_op = '0;
    logic [4:0]  in_dst = '0;
    logic [4:0]  in_src = '0;
    logic [31:0] in_imm = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_data;
    logic        out_last;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    macro_expander uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_op     (in_op),
        .in_dst    (in_dst),
        .in_src    (in_src),
        .in_imm    (in_imm),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .out_last  (out_last)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected <= %0d", cycles, WATCHDOG);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rword(int rs, int rt, int rd, int sh, int fn);
        return (32'(rs) << 21) | (32'(rt) << 16) | (32'(rd) << 11) | (32'(sh) << 6) | 32'(fn);
    endfunction

    function automatic logic [31:0] iword(int opc, int rs, int rt, logic [31:0] imm);
        return (32'(opc) << 26) | (32'(rs) << 21) | (32'(rt) << 16) | (imm & 32'h0000FFFF);
    endfunction

    function automatic logic fits(logic [31:0] v);
        return ($signed(v) >= -32768) && ($signed(v) <= 32767);
    endfunction

    // Drive one macro and check every word, the last flag and the handshake.
    task automatic run(input int op, input int dst, input int src,
                       input logic [31:0] imm, input int stall);
        logic [31:0] ew [3];
        int          n;
        int          k;
        int          cyc;
        int          amt;
        string       tag;
        logic        rdy;
        ew[0] = '0; ew[1] = '0; ew[2] = '0;
        n = 1;
        amt = int'(imm & 32'd31);
        case (op)
            1: begin tag = "R5 move"; ew[0] = rword(0, src, dst, 0, 32); end
            2: begin
                if (fits(imm)) begin
                    tag = "R6 li short"; ew[0] = iword(8, 0, dst, imm);
                end else begin
                    tag = "R7 li long"; n = 2;
                    ew[0] = iword(15, 0, dst, imm >> 16);
                    ew[1] = iword(13, dst, dst, imm);
                end
            end
            3: begin
                if (amt == 0) begin
                    tag = "R9 rotate zero";
                end else begin
                    tag = "R8 rotate"; n = 3;
                    ew[0] = rword(0, dst, 1, amt, 2);
                    ew[1] = rword(0, dst, dst, 32 - amt, 0);
                    ew[2] = rword(dst, 1, dst, 0, 37);
                end
            end
            4: begin
                if (fits(imm)) begin
                    tag = "R11 addu short"; ew[0] = iword(9, src, dst, imm);
                end else begin
                    tag = "R12 addu long"; n = 3;
                    ew[0] = iword(15, 0, 1, imm >> 16);
                    ew[1] = iword(13, 1, 1, imm);
                    ew[2] = rword(src, 1, dst, 0, 33);
                end
            end
            default: tag = "R10 nop";
        endcase
        @(negedge clk);
        check("R2 ready when idle", 32'(in_ready), 32'd1);
        in_valid = 1'b1;
        in_op = 3'(op); in_dst = 5'(dst); in_src = 5'(src); in_imm = imm;
        @(negedge clk);
        in_valid = 1'b0;
        in_imm = ~imm;
        k = 0;
        cyc = 0;
        while (k < n && cyc < 40) begin
            check("R2 busy not ready", 32'(in_ready), 32'd0);
            rdy = (stall == 0) ? 1'b1 : ((cyc % 2) == 1);
            out_ready = rdy;
            check({tag, " valid"}, 32'(out_valid), 32'd1);
            // Whole-word compare also covers the R13 field layout; repeated
            // compares while stalled cover R3.
            check({tag, " R13 word"}, out_data, ew[k]);
            check({tag, " R4 last"}, 32'(out_last), 32'(k == n - 1));
            if (rdy) k++;
            cyc++;
            @(negedge clk);
        end
        out_ready = 1'b0;
        check("R2 idle after last", 32'({out_valid, in_ready}), 32'b01);
    endtask

    initial begin
        logic [31:0] vals [9];
        vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001; vals[2] = 32'h0000_7FFF;
        vals[3] = 32'h0000_8000; vals[4] = 32'hFFFF_8000; vals[5] = 32'hFFFF_7FFF;
        vals[6] = 32'hFFFF_FFFF; vals[7] = 32'h1234_5678; vals[8] = 32'h0001_0000;

        repeat (3) @(negedge clk);
        check("R1 reset idle", 32'({out_valid, in_ready}), 32'b01);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", 32'({out_valid, in_ready}), 32'b01);

        for (int p = 0; p < 4; p++) begin
            int d;
            int s;
            d = (p == 0) ? 31 : (p == 1) ? 2 : (p == 2) ? 21 : 10;
            s = (p == 0) ? 0  : (p == 1) ? 29 : (p == 2) ? 10 : 21;
            run(1, d, s, 32'h0, p % 2);
            for (int v = 0; v < 9; v++) begin
                run(2, d, s, vals[v], (v + p) % 2);
                run(4, d, s, vals[v], (v + p + 1) % 2);
            end
        end

        for (int a = 0; a < 32; a++) run(3, 7 + (a % 20), 3, 32'(a), a % 2);
        run(3, 12, 0, 32'hFFFF_FFE0, 1);
        run(3, 12, 0, 32'h0000_0125, 0);
        for (int o = 0; o < 8; o++) if (o == 0 || o >= 5) run(o, 9, 9, 32'hDEAD_BEEF, o % 2);

        // Reset in the middle of a three-word expansion (R1).
        @(negedge clk);
        in_valid = 1'b1; in_op = 3'd3; in_dst = 5'd4; in_imm = 32'd8;
        @(negedge clk);
        in_valid = 1'b0; out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 mid-sequence reset", 32'({out_valid, in_ready}), 32'b01);
        run(1, 5, 6, 32'h0, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule